// File: doc/BRIEF.md
# Multi-Rail Power Sequencing Controller

This block drives the internal enables of a set of regulator rails (eight by default) and a wake output that starts the system. Each rail asks to start either through its own pin or, when software mode is selected, through a register bit. A rail starts only while the system is awake. It then waits a fixed enable delay. If its discharge-wait option is set, it also waits until its comparator reports that the output has fallen low. The comparator flags and the register bits are plain inputs.

A system state machine runs above the rails. After reset it stays in `S_INHIBIT` and ignores every request for a fixed period, then moves to `S_IDLE`. A wake request moves it to `S_WAIT_PON` and raises the wake output. From there, asserting the power-on input moves it to `S_ON`. If the power-on input is not asserted within the window, the window expires and the machine enters `S_SHUTDOWN`. Dropping the power-on input while in `S_ON` also leads to `S_SHUTDOWN`. `S_SHUTDOWN` lasts one cycle and returns to `S_IDLE`.

Each rail has its own state machine:
- `R_OFF` moves to `R_DELAY` on an armed request.
- `R_DELAY` moves to `R_ON` when the count ends, or to `R_DISCH` when a discharge is still pending.
- `R_DISCH` moves to `R_ON` when the output-low flag is seen.
- Any state returns to `R_OFF` when the request is lost or the system shuts down.
- A rail in the keep-alive mask does not leave `R_ON` on shutdown.

All delays are set in microseconds and converted to clock cycles from the clock-frequency parameter.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: For INH_CYC cycles after reset, the wake request and all rail requests are ignored: `wake_o` and every `rail_en_o` bit stay 0.
- R2: In idle, a high `wake_req_i` raises `wake_o` after the next clock edge. `wake_o` stays high for as long as `pwr_on_i` is asserted within the window.
- R3: If `pwr_on_i` stays low for WIN_CYC cycles after `wake_o` rises, `wake_o` falls after exactly WIN_CYC edges and a normal shutdown follows.
- R4: While the system is on, `pwr_on_i` falling causes a shutdown at the same edge. At that edge `wake_o` falls and the non-kept rails turn off.
- R5: A rail request that is high while the system is awake raises that rail's enable exactly EN_CYC edges after the first edge at which the request is seen.
- R6: A request that drops during the delay cancels the start. A new start needs the request low and then high again, and it restarts the full delay. A request held high across a shutdown does not restart the rail.
- R7: When bit i of `wait_dis_i` is 1 and `out_low_i[i]` is 0 at the end of the delay, the rail stays off and `disch_wait_o[i]` is 1. The enable rises at the edge at which `out_low_i[i]` is seen at 1.
- R8: While `sw_mode_i` is 1, each rail's request is bit i of `reg_en_i` and `pin_en_i` has no effect.
- R9: On shutdown, rails whose bit in `keep_mask_i` is 1 stay enabled. This holds even if their request drops in the shutdown cycle. All other rails turn off.
- R10: While the system is on, an enabled rail whose request goes low turns off at the next edge.
- R11: While the system is idle, no rail starts, whatever its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_req_i | input | 1 | Start-up request |
| pwr_on_i | input | 1 | Power-on hold from the system controller |
| pin_en_i | input | N_RAILS | Per-rail enable pins |
| out_low_i | input | N_RAILS | Per-rail flag: output below the discharge threshold |
| sw_mode_i | input | 1 | 1: rails follow `reg_en_i` instead of the pins |
| reg_en_i | input | N_RAILS | Per-rail register enable bits |
| wait_dis_i | input | N_RAILS | Per-rail discharge-wait select |
| keep_mask_i | input | N_RAILS | Per-rail keep-alive select |
| wake_o | output | 1 | Wake output |
| rail_en_o | output | N_RAILS | Per-rail internal enable |
| disch_wait_o | output | N_RAILS | Per-rail flag: waiting for the output to discharge |

## Verification
The critical coincidence is a shutdown that arrives in the same cycle as a request change on a keep-alive rail. This matches a rail whose pin is tied to wake, where the pin drops as wake drops. The bench lowers `pwr_on_i` and the pin of a kept rail on the same clock edge. At that edge the kept rail must stay enabled while a non-kept rail with its pin still high turns off. A second coincidence is a request that is still high when the system next wakes; the judgement is that such a rail stays off until its request is toggled.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        S_INHIBIT,
        S_IDLE,
        S_WAIT_PON,
        S_ON,
        S_SHUTDOWN
    } sys_state_e;

    typedef enum logic [1:0] {
        R_OFF,
        R_DELAY,
        R_DISCH,
        R_ON
    } rail_state_e;

    // Microseconds to clock cycles, at least one cycle.
    function automatic int unsigned us_to_cyc(longint unsigned hz, longint unsigned us);
        longint unsigned c;
        c = (hz * us) / 64'd1000000;
        return (c == 0) ? 1 : int'(c);
    endfunction

endpackage

// File: rtl/pwr_seq_sys.sv
module pwr_seq_sys
    import pwr_seq_pkg::*;
#(
    parameter int unsigned INH_CYC = 16,
    parameter int unsigned WIN_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_req_i,
    input  logic pwr_on_i,
    output logic wake_o,
    output logic active_o
);
    localparam int unsigned MAXC = (INH_CYC > WIN_CYC) ? INH_CYC : WIN_CYC;
    localparam int unsigned CW   = $clog2(MAXC + 1);

    sys_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic            win_end, sd_now;

    assign win_end = (cnt_q == CW'(WIN_CYC - 1));
    assign sd_now  = ((state_q == S_ON) && !pwr_on_i) ||
                     ((state_q == S_WAIT_PON) && !pwr_on_i && win_end);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_INHIBIT:  if (cnt_q == CW'(INH_CYC - 1)) state_d = S_IDLE;
            S_IDLE:     if (wake_req_i) state_d = S_WAIT_PON;
            S_WAIT_PON: if (pwr_on_i) state_d = S_ON;
                        else if (win_end) state_d = S_SHUTDOWN;
            S_ON:       if (!pwr_on_i) state_d = S_SHUTDOWN;
            S_SHUTDOWN: state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_INHIBIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) cnt_q <= '0;
            else if (state_q == S_INHIBIT || state_q == S_WAIT_PON) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        wake_o   = (state_q == S_WAIT_PON) || (state_q == S_ON);
        active_o = wake_o && !sd_now;
    end

    assert_wake_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> $past(wake_req_i));
    assert_wake_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ON && pwr_on_i) |=> wake_o);
    assert_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT_PON && win_end && !pwr_on_i) |=> !wake_o);
    assert_inhibit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_INHIBIT) |=> (state_q != S_WAIT_PON));
endmodule

// File: rtl/pwr_seq_rail.sv
module pwr_seq_rail
    import pwr_seq_pkg::*;
#(
    parameter int unsigned EN_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic active_i,
    input  logic keep_i,
    input  logic wait_dis_i,
    input  logic out_low_i,
    output logic rail_en_o,
    output logic disch_wait_o
);
    localparam int unsigned CW = $clog2(EN_CYC + 1);

    rail_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          armed_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_OFF:   if (active_i && req_i && armed_q) state_d = R_DELAY;
            R_DELAY: if (!active_i || !req_i) state_d = R_OFF;
                     else if (cnt_q == CW'(EN_CYC - 1))
                         state_d = (wait_dis_i && !out_low_i) ? R_DISCH : R_ON;
            R_DISCH: if (!active_i || !req_i) state_d = R_OFF;
                     else if (out_low_i) state_d = R_ON;
            R_ON:    if (active_i ? !req_i : !keep_i) state_d = R_OFF;
            default: state_d = R_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= R_OFF;
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == R_DELAY && state_d == R_DELAY) ? cnt_q + 1'b1 : '0;
            if (!req_i) armed_q <= 1'b1;
            else if (state_q == R_OFF && state_d == R_DELAY) armed_q <= 1'b0;
        end
    end

    always_comb begin
        rail_en_o    = (state_q == R_ON);
        disch_wait_o = (state_q == R_DISCH);
    end

    assert_start_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_en_o) |-> ($past(req_i) && $past(active_i)));
    assert_discharged_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_en_o) |-> (!$past(wait_dis_i) || $past(out_low_i)));
    assert_shutdown_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_en_o && !active_i && !keep_i) |=> !rail_en_o);
    assert_req_drop_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_en_o && active_i && !req_i) |=> !rail_en_o);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int unsigned N_RAILS     = 8,
    parameter int unsigned CLK_HZ      = 125_000_000,
    parameter int unsigned EN_DELAY_US = 200,
    parameter int unsigned PON_WIN_US  = 2000,
    parameter int unsigned INHIBIT_US  = 2000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wake_req_i,
    input  logic               pwr_on_i,
    input  logic [N_RAILS-1:0] pin_en_i,
    input  logic [N_RAILS-1:0] out_low_i,
    input  logic               sw_mode_i,
    input  logic [N_RAILS-1:0] reg_en_i,
    input  logic [N_RAILS-1:0] wait_dis_i,
    input  logic [N_RAILS-1:0] keep_mask_i,
    output logic               wake_o,
    output logic [N_RAILS-1:0] rail_en_o,
    output logic [N_RAILS-1:0] disch_wait_o
);
    localparam int unsigned EN_CYC  = us_to_cyc(CLK_HZ, EN_DELAY_US);
    localparam int unsigned WIN_CYC = us_to_cyc(CLK_HZ, PON_WIN_US);
    localparam int unsigned INH_CYC = us_to_cyc(CLK_HZ, INHIBIT_US);

    logic               active_w;
    logic [N_RAILS-1:0] req_w;

    assign req_w = sw_mode_i ? reg_en_i : pin_en_i;

    pwr_seq_sys #(.INH_CYC(INH_CYC), .WIN_CYC(WIN_CYC)) u_sys (
        .clk(clk), .rst_n(rst_n), .wake_req_i(wake_req_i), .pwr_on_i(pwr_on_i),
        .wake_o(wake_o), .active_o(active_w)
    );

    for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
        pwr_seq_rail #(.EN_CYC(EN_CYC)) u_rail (
            .clk(clk), .rst_n(rst_n), .req_i(req_w[i]), .active_i(active_w),
            .keep_i(keep_mask_i[i]), .wait_dis_i(wait_dis_i[i]),
            .out_low_i(out_low_i[i]), .rail_en_o(rail_en_o[i]),
            .disch_wait_o(disch_wait_o[i])
        );
    end
endmodule

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb;
    localparam int N   = 8;
    localparam int HZ  = 100_000;
    localparam int EN  = 20;   // 200 us at 100 kHz
    localparam int WIN = 200;  // 2000 us
    localparam int INH = 200;  // 2000 us

    logic clk = 1'b0, rst_n = 1'b0;
    logic wake_req = 0, pwr_on = 0, sw_mode = 0;
    logic [N-1:0] pin = '0, olow = '0, reg_en = '0, wdis = '0, keep = '0;
    logic wake;
    logic [N-1:0] en, dwait;
    int tests = 0, fails = 0;

    // {rail[5:3], wait_dis[2], out_low[1], expect_on[0]}
    localparam logic [5:0] VEC [4] = '{6'b000_0_0_1, 6'b011_1_1_1, 6'b101_1_0_0, 6'b111_0_0_1};

    always #4 clk = ~clk;

    pwr_seq_ctrl #(.N_RAILS(N), .CLK_HZ(HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .wake_req_i(wake_req), .pwr_on_i(pwr_on),
        .pin_en_i(pin), .out_low_i(olow), .sw_mode_i(sw_mode), .reg_en_i(reg_en),
        .wait_dis_i(wdis), .keep_mask_i(keep), .wake_o(wake), .rail_en_o(en),
        .disch_wait_o(dwait)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wake_req = 1; pin = '1;
        tick(3); rst_n = 1;
        tick(INH - 5);
        chk("R1 wake in inhibit", wake, 0);
        chk("R1 rails in inhibit", en, 0);
        wake_req = 0; pin = '0;
        tick(10);
        chk("R1 idle after inhibit", wake, 0);
        pin[6] = 1; tick(EN + 3);
        chk("R11 no start in idle", en, 0);
        pin[6] = 0;
        wake_req = 1; tick(1); wake_req = 0;
        chk("R2 wake rises", wake, 1);
        tick(40); pwr_on = 1; tick(WIN + 10);
        chk("R2 wake held", wake, 1);

        foreach (VEC[k]) begin
            automatic int r = int'(VEC[k][5:3]);
            wdis[r] = VEC[k][2]; olow[r] = VEC[k][1]; pin[r] = 1;
            tick(EN);
            chk("R5 not early", en[r], 0);
            tick(1);
            chk("R5 enable after delay", en[r], VEC[k][0]);
            chk("R7 wait flag", dwait[r], !VEC[k][0]);
            if (!VEC[k][0]) begin
                olow[r] = 1; tick(1);
                chk("R7 on after discharge", en[r], 1);
                chk("R7 wait flag clears", dwait[r], 0);
            end
            wdis[r] = 0;
        end
        chk("R5 rails on", en, 8'b1010_1001);
        pin[7] = 0; tick(1);
        chk("R10 pin low turns off", en[7], 0);

        pin[2] = 1; tick(EN / 2); pin[2] = 0; tick(EN + 2);
        chk("R6 cancel", en[2], 0);
        pin[2] = 1; tick(EN);
        chk("R6 full delay restart early", en[2], 0);
        tick(1);
        chk("R6 full delay restart", en[2], 1);

        reg_en = 8'b0010_1101; sw_mode = 1;
        pin[1] = 1; tick(EN + 3);
        chk("R8 pin ignored", en[1], 0);
        reg_en[1] = 1; tick(EN + 1);
        chk("R8 register start", en, 8'b0010_1111);
        sw_mode = 0;
        tick(2);

        keep = 8'b0000_1010;
        pwr_on = 0; pin[1] = 0; tick(1);
        chk("R4 wake falls", wake, 0);
        chk("R9 keep-alive only", en, 8'b0000_1010);
        tick(EN + 3);
        chk("R11 idle holds", en, 8'b0000_1010);

        wake_req = 1; tick(1); wake_req = 0; tick(5); pwr_on = 1; tick(EN + 3);
        chk("R6 held pin no restart", en, 8'b0000_1000);
        pin[0] = 0; tick(1); pin[0] = 1; tick(EN + 1);
        chk("R6 toggled pin restarts", en[0], 1);

        pwr_on = 0; tick(1);
        chk("R9 second shutdown", en, 8'b0000_1000);
        tick(3);
        wake_req = 1; tick(1); wake_req = 0;
        chk("R3 wake up again", wake, 1);
        tick(WIN - 1);
        chk("R3 window still open", wake, 1);
        tick(1);
        chk("R3 window expired", wake, 0);
        chk("R3 keep rail survives", en, 8'b0000_1000);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule